// File: doc/BRIEF.md
# Short-Vector Lane Shuffle with Constant Fill

This block rearranges the lanes of a short vector of up to four 32-bit elements in one registered step. A 12-bit control word holds one 3-bit code per destination lane. A code picks a source lane, loads a floating-point constant (0.0 or 1.0), or keeps the lane's current destination value. The codes that keep a value act as a write mask built into the control word.

The caller presents a source group, the current destination group, the control word and an active length of 1 to 4, and pulses a start strobe. One clock later the result group appears together with a done strobe. The result stays unchanged until the next start. Lanes at or beyond the active length always keep their prior destination value.

Top module: `lane_shuffle`

## Requirements
- R1: While reset (active-low, synchronous) is asserted, the result bus clears to all zeros and the done strobe is low.
- R2: done_o is high in the cycle after a cycle with start_i high, and low otherwise. The result is updated only in that cycle and holds between starts.
- R3: For an active lane s, codes 0 to 3 in ctrl_i[3s+2:3s] copy source lane (code) into result lane s.
- R4: For an active lane, code 4 writes 32'h00000000 (floating-point 0.0).
- R5: For an active lane, code 5 writes 32'h3F800000 (floating-point 1.0).
- R6: For an active lane, codes 6 and 7 leave the lane equal to its value on the destination input.
- R7: Lanes with index at or above len_i (len_i in 1..4, encoded as a 3-bit count) take their value from the destination input, whatever their code.
- R8: A copy code may name a source lane at or beyond len_i. The selected lane is still read from the full 4-lane source bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start strobe for one operation |
| src_i | input | 128 | Source group, lane k at bits [32k+31:32k] |
| dst_i | input | 128 | Prior destination group, same layout |
| ctrl_i | input | 12 | Per-lane 3-bit codes, lane s at [3s+2:3s] |
| len_i | input | 3 | Active lane count, 1 to 4 |
| res_o | output | 128 | Result group |
| done_o | output | 1 | Result valid, one cycle after start |

## Verification
Every result is due exactly one clock edge after its start strobe. The bench drives its inputs on the falling edge, waits for one rising edge, and samples res_o and done_o on the following falling edge. In the next cycle it checks that done_o has dropped and that res_o still holds the previous result. The inputs are also changed during that idle cycle, so a result that moves without a start is seen there.

// File: rtl/lane_shuffle_pkg.sv
// Package: shared widths and constant encodings for the lane shuffle.
// Assumes 32-bit single-precision elements.
package lane_shuffle_pkg;
    parameter int unsigned ELEM_W  = 32;
    parameter int unsigned LANES   = 4;
    parameter int unsigned CODE_W  = 3;
    localparam int unsigned SEL_W  = $clog2(LANES);
    localparam int unsigned LEN_W  = $clog2(LANES + 1);
    localparam logic [ELEM_W-1:0] FP_ZERO = 32'h0000_0000;
    localparam logic [ELEM_W-1:0] FP_ONE  = 32'h3F80_0000;

    typedef enum logic [1:0] {
        ACT_COPY = 2'd0,
        ACT_ZERO = 2'd1,
        ACT_ONE  = 2'd2,
        ACT_KEEP = 2'd3
    } lane_act_e;
endpackage

// File: rtl/lane_code_decode.sv
// Module: lane_code_decode
// Turns one 3-bit lane code and the lane's active flag into an action and
// a source index. Purely combinational. Assumes the code width is 3.
module lane_code_decode
    import lane_shuffle_pkg::*;
(
    input  logic [CODE_W-1:0] code_i,
    input  logic              active_i,
    output lane_act_e         act_o,
    output logic [SEL_W-1:0]  sel_o
);
    // Classify the code; inactive lanes are always kept.
    always_comb begin
        sel_o = code_i[SEL_W-1:0];
        if (!active_i)                act_o = ACT_KEEP;
        else if (!code_i[CODE_W-1])   act_o = ACT_COPY;
        else if (code_i == 3'd4)      act_o = ACT_ZERO;
        else if (code_i == 3'd5)      act_o = ACT_ONE;
        else                          act_o = ACT_KEEP;
    end
endmodule

// File: rtl/lane_mux.sv
// Module: lane_mux
// Produces the next value of one destination lane from the full source bus,
// the lane's prior value and a decoded action. Combinational.
module lane_mux
    import lane_shuffle_pkg::*;
(
    input  logic [LANES*ELEM_W-1:0] src_i,
    input  logic [ELEM_W-1:0]       prior_i,
    input  lane_act_e               act_i,
    input  logic [SEL_W-1:0]        sel_i,
    output logic [ELEM_W-1:0]       val_o
);
    logic [ELEM_W-1:0] picked;

    // Select the source element named by sel_i over the whole 4-lane bus.
    always_comb picked = src_i[sel_i*ELEM_W +: ELEM_W];

    // Apply the action.
    always_comb begin
        unique case (act_i)
            ACT_COPY: val_o = picked;
            ACT_ZERO: val_o = FP_ZERO;
            ACT_ONE:  val_o = FP_ONE;
            default:  val_o = prior_i;
        endcase
    end
endmodule

// File: rtl/lane_shuffle.sv
// Module: lane_shuffle (top)
// Registered per-lane shuffle with constant fill and an immediate write mask.
// Assumes len_i is in 1..LANES when start_i is high. The result is held
// until the next start.
module lane_shuffle
    import lane_shuffle_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    input  logic [LANES*ELEM_W-1:0] src_i,
    input  logic [LANES*ELEM_W-1:0] dst_i,
    input  logic [LANES*CODE_W-1:0] ctrl_i,
    input  logic [LEN_W-1:0]        len_i,
    output logic [LANES*ELEM_W-1:0] res_o,
    output logic                    done_o
);
    logic [LANES*ELEM_W-1:0] next_res;

    for (genvar s = 0; s < LANES; s++) begin : g_lane
        lane_act_e        act;
        logic [SEL_W-1:0] sel;
        logic             active;

        // Lane is processed only when its index is below the length.
        always_comb active = (LEN_W'(s) < len_i);

        lane_code_decode u_dec (
            .code_i  (ctrl_i[s*CODE_W +: CODE_W]),
            .active_i(active),
            .act_o   (act),
            .sel_o   (sel)
        );

        lane_mux u_mux (
            .src_i  (src_i),
            .prior_i(dst_i[s*ELEM_W +: ELEM_W]),
            .act_i  (act),
            .sel_i  (sel),
            .val_o  (next_res[s*ELEM_W +: ELEM_W])
        );

        // R7
        inactive_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (start_i && !active) |=> res_o[s*ELEM_W +: ELEM_W] == $past(dst_i[s*ELEM_W +: ELEM_W]));
        // R4
        zero_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (start_i && active && ctrl_i[s*CODE_W +: CODE_W] == 3'd4) |=> res_o[s*ELEM_W +: ELEM_W] == 32'h0);
        // R5
        one_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (start_i && active && ctrl_i[s*CODE_W +: CODE_W] == 3'd5) |=> res_o[s*ELEM_W +: ELEM_W] == 32'h3F800000);
    end

    // Capture the result and raise done one cycle after start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_o  <= '0;
            done_o <= 1'b0;
        end else begin
            done_o <= start_i;
            if (start_i) res_o <= next_res;
        end
    end

    // R2
    done_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o == $past(start_i));
    // R2
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> $stable(res_o));
    // R1
    reset_chk: assert property (@(posedge clk)
        !rst_n |=> (res_o == '0 && !done_o));
endmodule

// File: tb/sim_lane_shuffle.sv
module sim_lane_shuffle;
    localparam int CLK_PERIOD = 10;
    logic clk = 0, rst_n = 0, start_i = 0;
    logic [127:0] src_i = '0, dst_i = '0, res_o;
    logic [11:0] ctrl_i = '0;
    logic [2:0] len_i = 3'd4;
    logic done_o;
    int checks = 0, fails = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lane_shuffle u0 (.clk, .rst_n, .start_i, .src_i, .dst_i, .ctrl_i, .len_i, .res_o, .done_o);

    function automatic logic [127:0] model(logic [127:0] s, logic [127:0] d, logic [11:0] c, logic [2:0] l);
        logic [127:0] r = d;
        for (int k = 0; k < 4; k++) begin
            logic [2:0] code = c[3*k +: 3];
            if (k < l) begin
                if (code < 4) r[32*k +: 32] = s[32*code[1:0] +: 32];
                else if (code == 4) r[32*k +: 32] = 32'h0;
                else if (code == 5) r[32*k +: 32] = 32'h3F800000;
            end
        end
        return r;
    endfunction

    task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run(string req, logic [127:0] s, logic [127:0] d, logic [11:0] c, logic [2:0] l);
        logic [127:0] exp = model(s, d, c, l);
        @(negedge clk);
        src_i = s; dst_i = d; ctrl_i = c; len_i = l; start_i = 1;
        @(negedge clk);
        start_i = 0;
        chk(req, res_o, exp);
        chk({req, " R2 done"}, {127'b0, done_o}, 128'd1);
        src_i = ~s; dst_i = ~d; ctrl_i = ~c;
        @(negedge clk);
        chk("R2 hold", res_o, exp);
        chk("R2 done low", {127'b0, done_o}, 128'd0);
    endtask

    initial begin
        logic [127:0] S, D;
        void'($urandom(32'd1234));
        S = {32'hDDDD0003, 32'hCCCC0002, 32'hBBBB0001, 32'hAAAA0000};
        D = {32'h44440003, 32'h33330002, 32'h22220001, 32'h11110000};
        repeat (3) @(negedge clk);
        chk("R1 reset res", res_o, '0);
        chk("R1 reset done", {127'b0, done_o}, '0);
        rst_n = 1;
        // R3 reverse and broadcast
        run("R3 reverse", S, D, {3'd0, 3'd1, 3'd2, 3'd3}, 3'd4);
        run("R3 broadcast", S, D, {3'd2, 3'd2, 3'd2, 3'd2}, 3'd4);
        // R4 R5 constants
        run("R4 R5 consts", S, D, {3'd5, 3'd4, 3'd5, 3'd4}, 3'd4);
        // R6 mask codes
        run("R6 mask", S, D, {3'd6, 3'd7, 3'd0, 3'd7}, 3'd4);
        // R7 short lengths
        run("R7 len1", S, D, {3'd4, 3'd4, 3'd4, 3'd5}, 3'd1);
        run("R7 len3", S, D, {3'd5, 3'd3, 3'd4, 3'd1}, 3'd3);
        // R8 source beyond length
        run("R8 far src", S, D, {3'd0, 3'd0, 3'd0, 3'd3}, 3'd2);
        // random mix
        for (int i = 0; i < 200; i++) begin
            logic [127:0] rs = {$urandom, $urandom, $urandom, $urandom};
            logic [127:0] rd = {$urandom, $urandom, $urandom, $urandom};
            logic [11:0] rc = 12'($urandom);
            logic [2:0] rl = 3'(1 + ($urandom % 4));
            run("R3-R8 random", rs, rd, rc, rl);
        end
        // R1 reset mid-run
        @(negedge clk); rst_n = 0;
        @(negedge clk);
        chk("R1 re-reset", res_o, '0);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule